// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects external interrupt request lines, arranged in groups of eight, and hands the processor at most one interrupt at a time. The request lines are sampled once per scan interval. A sampled request stays pending until the processor accepts it. A pending line can be offered only when two conditions hold: its bit in the group's arm mask is set, and its whole group is enabled.

While the processor signals an instruction boundary, which is the point just before the next fetch, the controller offers the lowest-numbered eligible line. With it comes that line's vector address, which is the first word of a two-word slot reserved for that line. The processor executes the service instruction found there and accepts the interrupt, which clears only that line's pending bit.

If the service instruction is a jump-and-mark, the processor reports it on a strobe. The controller then blocks all further offers until software clears the block through the write port. The same write port loads the arm masks and the group enables.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no request is offered, the inhibit flag is clear, every arm mask is all zeros and every group is disabled. Requests that arrive before software arms and enables lines are not offered.
- R2: Request lines are sampled once every SCAN_CYC clocks. A line found high at a sample stays pending after the line falls, until it is accepted.
- R3: A pending line is offered only when its arm bit is 1 and its group's enable bit is 1. Line 8*g+k belongs to group g at bit k.
- R4: When several eligible lines are pending, the one with the lowest index is offered, whether the lines share a group or not.
- R5: While a request is offered, line_o carries the line index and vec_o equals VEC_BASE + 2*line_o.
- R6: req_o is high only while boundary_i is high and the inhibit flag is clear.
- R7: Asserting ack_i while req_o is high clears the pending bit of the offered line only. Other pending lines are then offered in turn.
- R8: A pulse on svc_jam_i sets inhibit_o on the next clock. inhibit_o stays set until a clear-inhibit write.
- R9: Write encoding on wr_kind_i: 0 loads wr_data_i into the arm mask of group wr_grp_i; 1 loads wr_data_i[0] into that group's enable; 2 clears the inhibit flag; 3 changes nothing.
- R10: Disarming a line or disabling its group does not discard its pending request. Re-arming or re-enabling offers it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_GROUPS*8 | Request lines |
| boundary_i | input | 1 | Processor is at an instruction boundary |
| ack_i | input | 1 | Processor accepts the offered request |
| svc_jam_i | input | 1 | Executed service instruction was jump-and-mark |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | Write kind (see R9) |
| wr_grp_i | input | GRP_W | Target group |
| wr_data_i | input | 8 | Write data |
| req_o | output | 1 | Interrupt offered |
| line_o | output | IDX_W | Index of offered line |
| vec_o | output | ADDR_W | Vector address of offered line |
| inhibit_o | output | 1 | Further interrupts blocked |

## Verification
The assertions assume that ack_i and svc_jam_i are single-cycle strobes raised only while a request is offered or a service instruction has completed. They also assume that the write port never sets the inhibit flag. The stimulus honours these assumptions: it raises ack_i only after it has observed req_o high, and it pulses svc_jam_i for exactly one clock. Request lines are held for more than one scan interval, so each request is captured no matter where the scan phase stands. The lines are then dropped before any check, which makes every offer come from the pending latch and not from the live line.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    WR_MASK    = 2'd0,
    WR_GEN     = 2'd1,
    WR_CLR_INH = 2'd2,
    WR_NOP     = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/prio_irq_scan.sv
module prio_irq_scan #(
  parameter int N_LINES  = 16,
  parameter int SCAN_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  localparam int CW = (SCAN_CYC > 1) ? $clog2(SCAN_CYC) : 1;

  logic [CW-1:0]      cnt_q;
  logic [N_LINES-1:0] pend_q;
  logic               tick;

  assign tick = (cnt_q == CW'(SCAN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      // a fresh sample wins over a same-cycle accept
      pend_q <= (pend_q & ~clr_i) | (tick ? irq_i : '0);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int N_GROUPS = 2,
  parameter int GRP_W    = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_kind_i,
  input  logic [GRP_W-1:0]      wr_grp_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  jam_i,
  output logic [N_GROUPS*8-1:0] arm_o,
  output logic [N_GROUPS-1:0]   gen_o,
  output logic                  inhibit_o
);
  logic inh_q;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [7:0] mask_q;
    logic       en_q;
    logic       sel;

    assign sel = wr_en_i && (wr_grp_i == GRP_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        en_q   <= 1'b0;
      end else begin
        if (sel && wr_kind_i == WR_MASK) mask_q <= wr_data_i;
        if (sel && wr_kind_i == WR_GEN)  en_q   <= wr_data_i[0];
      end
    end

    assign arm_o[g*8 +: 8] = mask_q;
    assign gen_o[g]        = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  inh_q <= 1'b0;
    else if (jam_i)                               inh_q <= 1'b1;
    else if (wr_en_i && wr_kind_i == WR_CLR_INH)  inh_q <= 1'b0;
  end

  assign inhibit_o = inh_q;
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [N_LINES-1:0] elig_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // descending scan so the lowest index is the last writer
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_GROUPS = 2,
  parameter int SCAN_CYC = 4,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40,
  localparam int N_LINES = N_GROUPS * 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int GRP_W   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               boundary_i,
  input  logic               ack_i,
  input  logic               svc_jam_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_kind_i,
  input  logic [GRP_W-1:0]   wr_grp_i,
  input  logic [7:0]         wr_data_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   line_o,
  output logic [ADDR_W-1:0]  vec_o,
  output logic               inhibit_o
);
  logic [N_LINES-1:0]  pend, arm, gen_x, elig, clr;
  logic [N_GROUPS-1:0] gen;
  logic                hit;
  logic [IDX_W-1:0]    idx;

  prio_irq_scan #(.N_LINES(N_LINES), .SCAN_CYC(SCAN_CYC)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .clr_i(clr), .pend_o(pend)
  );

  prio_irq_regs #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
    .wr_grp_i(wr_grp_i), .wr_data_i(wr_data_i), .jam_i(svc_jam_i),
    .arm_o(arm), .gen_o(gen), .inhibit_o(inhibit_o)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_gen
    assign gen_x[g*8 +: 8] = {8{gen[g]}};
  end

  assign elig = pend & arm & gen_x;

  prio_irq_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_pick (
    .elig_i(elig), .hit_o(hit), .idx_o(idx)
  );

  assign req_o  = boundary_i && !inhibit_o && hit;
  assign line_o = idx;
  assign vec_o  = ADDR_W'(VEC_BASE) + (ADDR_W'(idx) << 1);
  assign clr    = (req_o && ack_i) ? (N_LINES'(1) << idx) : '0;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int N_LINES  = 16,
  parameter int IDX_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 'h40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               boundary_i,
  input logic               svc_jam_i,
  input logic               wr_en_i,
  input logic [1:0]         wr_kind_i,
  input logic               req_o,
  input logic [IDX_W-1:0]   line_o,
  input logic [ADDR_W-1:0]  vec_o,
  input logic               inhibit_o,
  input logic [N_LINES-1:0] elig
);
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (boundary_i && !inhibit_o)); // R6
  AST_REQ_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> elig[line_o]); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((elig & ((N_LINES'(1) << line_o) - N_LINES'(1))) == '0)); // R4
  AST_VEC_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vec_o == ADDR_W'(VEC_BASE + 2 * int'(line_o)))); // R5
  AST_INH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_jam_i |=> inhibit_o); // R8
  AST_INH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_o && !(wr_en_i && wr_kind_i == 2'd2)) |=> inhibit_o); // R8
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .N_LINES(N_LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i), .svc_jam_i(svc_jam_i),
  .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .req_o(req_o), .line_o(line_o),
  .vec_o(vec_o), .inhibit_o(inhibit_o), .elig(elig)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int SCAN = 4;
  localparam int BASE = 'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        bnd = 1'b0, ack = 1'b0, jam = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [0:0]  wr_grp = '0;
  logic [7:0]  wr_data = '0;
  logic        req_o, inhibit_o;
  logic [3:0]  line_o;
  logic [15:0] vec_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.N_GROUPS(2), .SCAN_CYC(SCAN), .ADDR_W(16), .VEC_BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .boundary_i(bnd), .ack_i(ack),
    .svc_jam_i(jam), .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_grp_i(wr_grp),
    .wr_data_i(wr_data), .req_o(req_o), .line_o(line_o), .vec_o(vec_o),
    .inhibit_o(inhibit_o)
  );

  typedef struct packed {
    logic [15:0] irq;
    logic [7:0]  m0;
    logic [7:0]  m1;
    logic [1:0]  gen;
    logic        req;
    logic [3:0]  line;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'h0001, 8'hFF, 8'hFF, 2'b11, 1'b1, 4'd0},
    '{16'h0090, 8'hFF, 8'hFF, 2'b11, 1'b1, 4'd4},
    '{16'h0090, 8'h80, 8'hFF, 2'b11, 1'b1, 4'd7},
    '{16'h0300, 8'hFF, 8'hFF, 2'b11, 1'b1, 4'd8},
    '{16'h0101, 8'hFF, 8'hFF, 2'b10, 1'b1, 4'd8},
    '{16'h0101, 8'hFF, 8'hFF, 2'b00, 1'b0, 4'd0},
    '{16'h8000, 8'h00, 8'h80, 2'b10, 1'b1, 4'd15},
    '{16'h0000, 8'hFF, 8'hFF, 2'b11, 1'b0, 4'd0}
  };

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic g, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_grp = g; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq(input logic [15:0] p);
    @(negedge clk);
    irq = p;
    repeat (SCAN + 1) @(negedge clk);
    irq = '0;
    @(negedge clk);
  endtask

  task automatic drain();
    wr(2'd0, 1'b0, 8'hFF); wr(2'd0, 1'b1, 8'hFF);
    wr(2'd1, 1'b0, 8'h01); wr(2'd1, 1'b1, 8'h01);
    bnd = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      if (!req_o) break;
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
    end
    bnd = 1'b0;
  endtask

  task automatic look();
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bnd = 1'b1;
    look();
    check("R1 req after reset", req_o, 0);
    check("R1 inhibit after reset", inhibit_o, 0);
    pulse_irq(16'hFFFF);
    look();
    check("R1 unarmed lines not offered", req_o, 0);
    wr(2'd1, 1'b0, 8'h01); wr(2'd1, 1'b1, 8'h01);
    look();
    check("R1 masks reset to zero", req_o, 0);
    bnd = 1'b0;
    drain();

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 1'b0, TBL[i].m0); wr(2'd0, 1'b1, TBL[i].m1);
      wr(2'd1, 1'b0, {7'd0, TBL[i].gen[0]}); wr(2'd1, 1'b1, {7'd0, TBL[i].gen[1]});
      pulse_irq(TBL[i].irq);
      bnd = 1'b1;
      look();
      check("R2 R3 req", req_o, TBL[i].req);
      if (TBL[i].req) begin
        check("R4 line", line_o, TBL[i].line);
        check("R5 vec", vec_o, BASE + 2 * TBL[i].line);
      end
      bnd = 1'b0;
      drain();
    end

    // R7 accept clears one line; R6 boundary gating
    pulse_irq(16'h0024);
    bnd = 1'b1;
    look();
    check("R7 first line", line_o, 2);
    ack = 1'b1; @(negedge clk); ack = 1'b0; #1;
    check("R7 other still pending", req_o, 1);
    check("R7 next line", line_o, 5);
    bnd = 1'b0; #1;
    check("R6 no boundary", req_o, 0);
    drain();

    // R10 disarm keeps pending, R9 nop write
    wr(2'd0, 1'b0, 8'h00);
    pulse_irq(16'h0008);
    bnd = 1'b1;
    look();
    check("R10 disarmed not offered", req_o, 0);
    wr(2'd0, 1'b0, 8'h08); #1;
    check("R10 rearm offers", req_o, 1);
    check("R10 rearm line", line_o, 3);
    wr(2'd3, 1'b0, 8'h00); #1;
    check("R9 nop keeps mask", req_o, 1);
    wr(2'd1, 1'b0, 8'h00); #1;
    check("R10 group off", req_o, 0);
    wr(2'd1, 1'b0, 8'h01); #1;
    check("R10 group on", line_o, 3);

    // R8 inhibit
    @(negedge clk); jam = 1'b1;
    @(negedge clk); jam = 1'b0; #1;
    check("R8 inhibit set", inhibit_o, 1);
    check("R6 inhibited no req", req_o, 0);
    wr(2'd0, 1'b0, 8'hFF); #1;
    check("R8 mask write keeps inhibit", inhibit_o, 1);
    wr(2'd3, 1'b0, 8'hFF); #1;
    check("R9 nop keeps inhibit", inhibit_o, 1);
    wr(2'd2, 1'b0, 8'h00); #1;
    check("R8 cleared", inhibit_o, 0);
    check("R8 req back", req_o, 1);
    bnd = 1'b0;
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule